// File: doc/BRIEF.md
# Phased Chip Reset Sequencer

This block orders the release of a chip from reset. It accepts three kinds of reset request. Power-on comes from several power-monitor sources, and any one of them is enough. Destructive requests and functional requests each arrive on their own input. The block then steps through a fixed series of phases before it hands the chip over to the boot core. Power-on and destructive requests start with a destructive stage that resets everything, memory contents included, and then run the whole functional series. A functional request skips the destructive stage. It enters the series at its first phase, so analog, debug, flash and memory state are kept.

The functional series has twelve phases, 0 to 11. Each phase switches on one more control and keeps the earlier ones on: memory isolation and monitor masking, crossbar disable, clock fallback to the internal RC clock, default dividers, PLL shutdown, oscillator shutdown, and the clocks that synchronous-reset modules need. Phase 7 holds the functional reset for a fixed number of clocks. Phases 8 to 10 each make a request and wait for its answer: the flash handshake, the configuration-record scan and the analog trim load. Phase 11 lets go of the open-drain reset pin. It then waits until the pin reads high and, when low-power debug is on, until the debugger acknowledges. A two-bit field reports the kind of the last reset.

Top module: `rst_phase_seq`

## Requirements
- R1: While any bit of `porSrc` is high, and from the first clock edge that sees it high, the block is in the destructive stage. In that stage `destRst`=1, `pinDrive`=1, `phaseOneHot`=0, all phase controls are 0 and `seqDone`=0. `lastKind` reads 2'b01 (power-on), and a power-on request arriving in the middle of a sequence has the same effect.
- R2: A `destReq` pulse with no power-on active puts the block in the destructive stage at the next edge, with `lastKind`=2'b10. The destructive stage lasts exactly DEST_LEN cycles, and then phase 0 follows.
- R3: A `funcReq` pulse with no power-on or destructive request puts the block in phase 0 at the next edge, with `lastKind`=2'b11. `destRst` stays low. When `destReq` and `funcReq` arrive together, the destructive request wins.
- R4: Bit k of `phaseOneHot` is high exactly while the block is in phase k (0 to 11). Phases 0 to 6 each last one cycle and come in rising order.
- R5: The controls turn on at these phases and stay on through phase 11: `memIsolate` and `monMask` at phase 0, `xbarOff` at 1, `clkFallback` at 2, `divDefault` at 3, `pllOff` at 4, `oscOff` at 5 and `syncClkEn` at 6. All of them are low in the destructive stage and after release.
- R6: In phase 7, `funcRst` is high for exactly SAFE_CYCLES consecutive cycles, and then phase 8 follows.
- R7: `flashReq`, `dcfStart` and `trimStart` are high only in phases 8, 9 and 10 respectively. Each of these phases moves on at the edge that samples its answer (`flashAck`, `dcfDone`, `trimDone`) high, and stays where it is otherwise.
- R8: `pinDrive` is high in the destructive stage and in phases 0 to 10. It is low in phase 11 and after release.
- R9: Phase 11 ends at the edge that samples `pinLevel` high together with either `dbgEnable` low or `dbgAck` high. At that edge `seqDone` goes to 1 and stays at 1 until the next request.
- R10: An answer input raised outside its own phase has no effect. `flashAck` seen in phase 7 does not shorten the count, and `dcfDone` or `trimDone` seen in phase 8 does not move the block on.
- R11: A request arriving in the middle of a sequence restarts the block at that request's entry point (the destructive stage or phase 0), and `lastKind` is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC clock |
| porSrc | input | NUM_POR | Power-monitor reset sources, high = reset |
| destReq | input | 1 | Destructive reset request, one-cycle pulse |
| funcReq | input | 1 | Functional reset request, one-cycle pulse |
| flashAck | input | 1 | Flash handshake answer (phase 8) |
| dcfDone | input | 1 | Configuration record scan finished (phase 9) |
| trimDone | input | 1 | Analog trim load finished (phase 10) |
| dbgEnable | input | 1 | Low-power debug enabled |
| dbgAck | input | 1 | Debugger acknowledge |
| pinLevel | input | 1 | Level read back from the external reset pin |
| phaseOneHot | output | 12 | Current functional phase, one-hot |
| destRst | output | 1 | Destructive stage active |
| memIsolate | output | 1 | Secure-core memories isolated |
| monMask | output | 1 | Fault and clock monitoring masked |
| xbarOff | output | 1 | Crossbar disabled |
| clkFallback | output | 1 | Clock muxes on internal RC clock |
| divDefault | output | 1 | Clock dividers at default |
| pllOff | output | 1 | PLL shut off |
| oscOff | output | 1 | Crystal oscillator shut off |
| syncClkEn | output | 1 | Clocks on for synchronous-reset modules |
| funcRst | output | 1 | Functional reset asserted |
| flashReq | output | 1 | Flash handshake request |
| dcfStart | output | 1 | Configuration scan start |
| trimStart | output | 1 | Trim load start |
| pinDrive | output | 1 | Open-drain enable pulling the reset pin low |
| seqDone | output | 1 | Sequence complete, boot core may start |
| lastKind | output | 2 | Kind of last reset: 01 power-on, 10 destructive, 11 functional |

## Verification
The bench builds the block with NUM_POR=3, DEST_LEN=5 and SAFE_CYCLES=64. A short destructive stage makes it practical to check its exact length and to run every entry path to release many times. The stated 64-cycle safe-clock count is kept, so the exact length of phase 7 is checked as it stands. Each run holds back every answer input and the reset pin so that the block can be seen stalled in phases 8 to 11. Requests are also injected in phases 7 and 9 to check restart and priority.

// File: rtl/rst_phase_pkg.sv
package rst_phase_pkg;

  localparam int NUM_PHASES = 12;
  localparam int NUM_LEVELS = 7;

  typedef enum logic [3:0] {
    PH_F0   = 4'd0,  PH_F1  = 4'd1,  PH_F2  = 4'd2,  PH_F3 = 4'd3,
    PH_F4   = 4'd4,  PH_F5  = 4'd5,  PH_F6  = 4'd6,  PH_F7 = 4'd7,
    PH_F8   = 4'd8,  PH_F9  = 4'd9,  PH_F10 = 4'd10, PH_F11 = 4'd11,
    PH_DEST = 4'd12, PH_DONE = 4'd13
  } phase_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_POWER = 2'd1,
    KIND_DESTR = 2'd2,
    KIND_FUNCT = 2'd3
  } kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  cntClr;
    logic  cntRun;
    logic  cntSafe;
    logic  kindLoad;
    kind_e kindVal;
  } strobe_t;

endpackage

// File: rtl/rst_phase_ctrl.sv
module rst_phase_ctrl
  import rst_phase_pkg::*;
(
  input  logic    clk,
  input  logic    porAny,
  input  logic    destReq,
  input  logic    funcReq,
  input  logic    flashAck,
  input  logic    dcfDone,
  input  logic    trimDone,
  input  logic    dbgEnable,
  input  logic    dbgAck,
  input  logic    pinLevel,
  input  logic    cntDone,
  output phase_e  phase,
  output strobe_t strb
);

  phase_e nextPhase;
  logic   releaseOk;

  assign releaseOk = pinLevel && (!dbgEnable || dbgAck);

  always_comb begin
    nextPhase    = phase;
    strb         = '0;
    strb.cntRun  = (phase == PH_DEST) || (phase == PH_F7);
    strb.cntSafe = (phase == PH_F7);
    if (destReq) begin
      nextPhase     = PH_DEST;
      strb.cntClr   = 1'b1;
      strb.kindLoad = 1'b1;
      strb.kindVal  = KIND_DESTR;
    end else if (funcReq) begin
      nextPhase     = PH_F0;
      strb.kindLoad = 1'b1;
      strb.kindVal  = KIND_FUNCT;
    end else begin
      case (phase)
        PH_DEST: if (cntDone) nextPhase = PH_F0;
        PH_F6: begin
          nextPhase   = PH_F7;
          strb.cntClr = 1'b1;
        end
        PH_F7:   if (cntDone)   nextPhase = PH_F8;
        PH_F8:   if (flashAck)  nextPhase = PH_F9;
        PH_F9:   if (dcfDone)   nextPhase = PH_F10;
        PH_F10:  if (trimDone)  nextPhase = PH_F11;
        PH_F11:  if (releaseOk) nextPhase = PH_DONE;
        PH_DONE: nextPhase = PH_DONE;
        default: nextPhase = phase_e'(phase + 4'd1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (porAny) phase <= PH_DEST;
    else        phase <= nextPhase;
  end

endmodule

// File: rtl/rst_phase_dp.sv
module rst_phase_dp
  import rst_phase_pkg::*;
#(
  parameter int DEST_LEN    = 8,
  parameter int SAFE_CYCLES = 64
) (
  input  logic    clk,
  input  logic    porAny,
  input  strobe_t strb,
  output logic    cntDone,
  output kind_e   lastKind
);

  localparam int MAXLEN = (DEST_LEN > SAFE_CYCLES) ? DEST_LEN : SAFE_CYCLES;
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] DEST_LAST = CW'(DEST_LEN - 1);
  localparam logic [CW-1:0] SAFE_LAST = CW'(SAFE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cntLast;

  assign cntLast = strb.cntSafe ? SAFE_LAST : DEST_LAST;
  assign cntDone = strb.cntRun && (cnt == cntLast);

  always_ff @(posedge clk) begin
    if (porAny || strb.cntClr) cnt <= '0;
    else if (strb.cntRun)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (porAny)             lastKind <= KIND_POWER;
    else if (strb.kindLoad) lastKind <= strb.kindVal;
  end

endmodule

// File: rtl/rst_phase_decode.sv
module rst_phase_decode
  import rst_phase_pkg::*;
(
  input  phase_e                  phase,
  output logic [NUM_PHASES-1:0]   phaseOneHot,
  output logic [NUM_LEVELS-1:0]   ctrlLevel,
  output logic                    destRst,
  output logic                    funcRst,
  output logic                    flashReq,
  output logic                    dcfStart,
  output logic                    trimStart,
  output logic                    pinDrive,
  output logic                    seqDone
);

  logic [3:0] idx;
  logic       inFunc;

  assign idx    = phase;
  assign inFunc = (idx <= 4'(NUM_PHASES - 1));

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_onehot
    assign phaseOneHot[i] = (idx == 4'(i));
  end

  for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
    assign ctrlLevel[k] = inFunc && (idx >= 4'(k));
  end

  assign destRst   = (phase == PH_DEST);
  assign funcRst   = (phase == PH_F7);
  assign flashReq  = (phase == PH_F8);
  assign dcfStart  = (phase == PH_F9);
  assign trimStart = (phase == PH_F10);
  assign pinDrive  = destRst || (idx <= 4'd10);
  assign seqDone   = (phase == PH_DONE);

endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rst_phase_pkg::*;
#(
  parameter int NUM_POR     = 3,
  parameter int DEST_LEN    = 8,
  parameter int SAFE_CYCLES = 64
) (
  input  logic               clk,
  input  logic [NUM_POR-1:0] porSrc,
  input  logic               destReq,
  input  logic               funcReq,
  input  logic               flashAck,
  input  logic               dcfDone,
  input  logic               trimDone,
  input  logic               dbgEnable,
  input  logic               dbgAck,
  input  logic               pinLevel,
  output logic [11:0]        phaseOneHot,
  output logic               destRst,
  output logic               memIsolate,
  output logic               monMask,
  output logic               xbarOff,
  output logic               clkFallback,
  output logic               divDefault,
  output logic               pllOff,
  output logic               oscOff,
  output logic               syncClkEn,
  output logic               funcRst,
  output logic               flashReq,
  output logic               dcfStart,
  output logic               trimStart,
  output logic               pinDrive,
  output logic               seqDone,
  output logic [1:0]         lastKind
);

  logic                  porAny;
  phase_e                phase;
  strobe_t               strb;
  logic                  cntDone;
  kind_e                 kind;
  logic [NUM_LEVELS-1:0] ctrlLevel;

  assign porAny = |porSrc;

  rst_phase_ctrl u_ctrl (
    .clk(clk), .porAny(porAny), .destReq(destReq), .funcReq(funcReq),
    .flashAck(flashAck), .dcfDone(dcfDone), .trimDone(trimDone),
    .dbgEnable(dbgEnable), .dbgAck(dbgAck), .pinLevel(pinLevel),
    .cntDone(cntDone), .phase(phase), .strb(strb)
  );

  rst_phase_dp #(.DEST_LEN(DEST_LEN), .SAFE_CYCLES(SAFE_CYCLES)) u_dp (
    .clk(clk), .porAny(porAny), .strb(strb), .cntDone(cntDone), .lastKind(kind)
  );

  rst_phase_decode u_dec (
    .phase(phase), .phaseOneHot(phaseOneHot), .ctrlLevel(ctrlLevel),
    .destRst(destRst), .funcRst(funcRst), .flashReq(flashReq),
    .dcfStart(dcfStart), .trimStart(trimStart), .pinDrive(pinDrive),
    .seqDone(seqDone)
  );

  assign memIsolate  = ctrlLevel[0];
  assign monMask     = ctrlLevel[0];
  assign xbarOff     = ctrlLevel[1];
  assign clkFallback = ctrlLevel[2];
  assign divDefault  = ctrlLevel[3];
  assign pllOff      = ctrlLevel[4];
  assign oscOff      = ctrlLevel[5];
  assign syncClkEn   = ctrlLevel[6];
  assign lastKind    = kind;

endmodule

// File: rtl/rst_phase_chk.sv
module rst_phase_chk #(
  parameter int SAFE_CYCLES = 64
) (
  input logic        clk,
  input logic        porAny,
  input logic        destReq,
  input logic        funcReq,
  input logic        flashAck,
  input logic        pinLevel,
  input logic        dbgEnable,
  input logic        dbgAck,
  input logic [11:0] phaseOneHot,
  input logic        destRst,
  input logic        funcRst,
  input logic        flashReq,
  input logic        pinDrive,
  input logic        seqDone,
  input logic [1:0]  lastKind
);

  int run;

  always_ff @(posedge clk) begin
    if (porAny)               run <= 0;
    else if (funcRst)         run <= run + 1;
    else if (!phaseOneHot[8]) run <= 0;
  end

  a_r4_phase_onehot: assert property (@(posedge clk) disable iff (porAny)
    $onehot0(phaseOneHot) && !(destRst && phaseOneHot != 12'd0));

  a_r2_dest_entry: assert property (@(posedge clk) disable iff (porAny)
    destReq |=> destRst && lastKind == 2'b10 && phaseOneHot == 12'd0);

  a_r3_func_entry: assert property (@(posedge clk) disable iff (porAny)
    (funcReq && !destReq) |=> phaseOneHot[0] && lastKind == 2'b11 && !destRst);

  a_r6_safe_count: assert property (@(posedge clk) disable iff (porAny)
    $rose(phaseOneHot[8]) |-> run == SAFE_CYCLES);

  a_r7_flash_wait: assert property (@(posedge clk) disable iff (porAny)
    (flashReq && !flashAck && !destReq && !funcReq) |=> flashReq);

  a_r8_pin_released: assert property (@(posedge clk) disable iff (porAny)
    (seqDone || phaseOneHot[11]) |-> !pinDrive);

  a_r8_pin_driven: assert property (@(posedge clk) disable iff (porAny)
    destRst |-> pinDrive);

  a_r9_release_cond: assert property (@(posedge clk) disable iff (porAny)
    $rose(seqDone) |-> $past(phaseOneHot[11]) && $past(pinLevel) &&
                       (!$past(dbgEnable) || $past(dbgAck)));

endmodule

bind rst_phase_seq rst_phase_chk #(.SAFE_CYCLES(SAFE_CYCLES)) u_chk (
  .clk(clk), .porAny(porAny), .destReq(destReq), .funcReq(funcReq),
  .flashAck(flashAck), .pinLevel(pinLevel), .dbgEnable(dbgEnable),
  .dbgAck(dbgAck), .phaseOneHot(phaseOneHot), .destRst(destRst),
  .funcRst(funcRst), .flashReq(flashReq), .pinDrive(pinDrive),
  .seqDone(seqDone), .lastKind(lastKind)
);

// File: tb/rst_phase_seq_tb.sv
module rst_phase_seq_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int NUM_POR     = 3;
  localparam int DEST_LEN    = 5;
  localparam int SAFE_CYCLES = 64;

  logic               clk = 1'b0;
  logic [NUM_POR-1:0] porSrc = '1;
  logic destReq = 0, funcReq = 0, flashAck = 0, dcfDone = 0, trimDone = 0;
  logic dbgEnable = 0, dbgAck = 0, pinLevel = 1;
  logic [11:0] phaseOneHot;
  logic destRst, memIsolate, monMask, xbarOff, clkFallback, divDefault;
  logic pllOff, oscOff, syncClkEn, funcRst, flashReq, dcfStart, trimStart;
  logic pinDrive, seqDone;
  logic [1:0] lastKind;
  logic [6:0] levels;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign levels = {syncClkEn, oscOff, pllOff, divDefault, clkFallback, xbarOff, memIsolate};

  rst_phase_seq #(.NUM_POR(NUM_POR), .DEST_LEN(DEST_LEN), .SAFE_CYCLES(SAFE_CYCLES)) u_dut (
    .clk(clk), .porSrc(porSrc), .destReq(destReq), .funcReq(funcReq),
    .flashAck(flashAck), .dcfDone(dcfDone), .trimDone(trimDone),
    .dbgEnable(dbgEnable), .dbgAck(dbgAck), .pinLevel(pinLevel),
    .phaseOneHot(phaseOneHot), .destRst(destRst), .memIsolate(memIsolate),
    .monMask(monMask), .xbarOff(xbarOff), .clkFallback(clkFallback),
    .divDefault(divDefault), .pllOff(pllOff), .oscOff(oscOff),
    .syncClkEn(syncClkEn), .funcRst(funcRst), .flashReq(flashReq),
    .dcfStart(dcfStart), .trimStart(trimStart), .pinDrive(pinDrive),
    .seqDone(seqDone), .lastKind(lastKind)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic destCount();
    int n = 0;
    while (!phaseOneHot[0] && n < 100) begin
      tick();
      n++;
    end
    chk("R2 destructive stage length", n, DEST_LEN);
  endtask

  // expects phase 0 at entry; runs through to release
  task automatic walk(input logic [1:0] kind, input logic useDbg);
    int n;
    for (int k = 0; k < 7; k++) begin
      chk("R4 phase order", phaseOneHot, 32'(1 << k));
      chk("R5 cumulative controls", levels, 32'((2 << k) - 1));
      chk("R8 pin driven", pinDrive, 1);
      if (k == 0) chk("R5 monitor mask", monMask, 1);
      tick();
    end
    n = 0;
    flashAck = 1;
    while (funcRst && n < 1000) begin
      n++;
      tick();
    end
    flashAck = 0;
    chk("R6 safe count length", n, SAFE_CYCLES);
    chk("R10 early flash ack ignored, at phase 8", phaseOneHot, 32'h100);
    dcfDone = 1; trimDone = 1;
    tick(2);
    dcfDone = 0; trimDone = 0;
    chk("R10 stray done ignored in phase 8", phaseOneHot, 32'h100);
    chk("R7 flash request held", flashReq, 1);
    flashAck = 1; tick(); flashAck = 0;
    chk("R7 advance to phase 9", phaseOneHot, 32'h200);
    chk("R7 scan start", {flashReq, dcfStart}, 2'b01);
    tick();
    chk("R7 phase 9 waits", phaseOneHot, 32'h200);
    dcfDone = 1; tick(); dcfDone = 0;
    chk("R7 trim start", {trimStart, phaseOneHot[10]}, 2'b11);
    pinLevel = 0;
    trimDone = 1; tick(); trimDone = 0;
    chk("R8 pin released in phase 11", {phaseOneHot[11], pinDrive}, 2'b10);
    chk("R5 controls held in phase 11", levels, 32'h7f);
    tick(2);
    chk("R9 waits for pin high", {phaseOneHot[11], seqDone}, 2'b10);
    pinLevel = 1;
    if (useDbg) begin
      dbgEnable = 1; dbgAck = 0;
      tick(2);
      chk("R9 waits for debug ack", {phaseOneHot[11], seqDone}, 2'b10);
      dbgAck = 1;
    end
    tick();
    dbgEnable = 0; dbgAck = 0;
    chk("R9 release", seqDone, 1);
    chk("R5 controls off after release", levels, 0);
    chk("R4 no phase after release", phaseOneHot, 0);
    chk("R11 kind kept", lastKind, kind);
    tick(3);
    chk("R9 done held", {seqDone, pinDrive}, 2'b10);
  endtask

  task automatic t_power();
    tick(3);
    chk("R1 destructive stage under power-on", {destRst, pinDrive, seqDone}, 3'b110);
    chk("R1 kind power-on", lastKind, 2'b01);
    chk("R1 no phase", phaseOneHot, 0);
    chk("R1 controls off", levels, 0);
    porSrc = 3'b010;
    tick(10);
    chk("R1 held by single source", {destRst, phaseOneHot[0]}, 2'b10);
    porSrc = '0;
    destCount();
    walk(2'b01, 1'b1);
  endtask

  task automatic t_func();
    funcReq = 1; tick(); funcReq = 0;
    chk("R3 functional entry at phase 0", phaseOneHot, 1);
    chk("R3 kind functional", lastKind, 2'b11);
    chk("R3 destructive skipped", destRst, 0);
    walk(2'b11, 1'b0);
  endtask

  task automatic t_prio();
    destReq = 1; funcReq = 1; tick(); destReq = 0; funcReq = 0;
    chk("R3 destructive wins", {destRst, phaseOneHot[0]}, 2'b10);
    chk("R2 kind destructive", lastKind, 2'b10);
    destCount();
    walk(2'b10, 1'b0);
  endtask

  task automatic t_restart();
    funcReq = 1; tick(); funcReq = 0;
    tick(7 + 10);
    chk("R6 in safe count", funcRst, 1);
    funcReq = 1; tick(); funcReq = 0;
    chk("R11 functional restart from phase 7", {phaseOneHot[0], funcRst}, 2'b10);
    chk("R11 kind functional", lastKind, 2'b11);
    walk(2'b11, 1'b0);
    funcReq = 1; tick(); funcReq = 0;
    tick(7 + SAFE_CYCLES);
    flashAck = 1; tick(); flashAck = 0;
    chk("R7 reached phase 9", phaseOneHot, 32'h200);
    destReq = 1; tick(); destReq = 0;
    chk("R11 destructive restart from phase 9", {destRst, pinDrive, dcfStart}, 3'b110);
    chk("R11 kind destructive", lastKind, 2'b10);
    tick(2);
    porSrc = 3'b100; tick(); porSrc = '0;
    chk("R1 power-on mid sequence", {destRst, lastKind}, 3'b101);
    destCount();
    walk(2'b01, 1'b0);
  endtask

  initial begin
    t_power();
    t_func();
    t_prio();
    t_restart();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule